// File: doc/BRIEF.md
# Truncated bfloat16 greater-than comparator

This block orders two 32-bit single-precision words as if both had first been cut down to bfloat16 precision. It answers one question, "is A greater than B", from the sign bit, the eight exponent bits and only the seven most significant fraction bits. The sixteen low fraction bits play no part. Operands are raw bit patterns. The block does no rounding, does no arithmetic, and gives NaN, infinity and denormal patterns no special treatment.

The flag is available at once from combinational logic, for use inside a single-cycle datapath. A registered copy with a valid strobe is also provided, so the compare can sit in a pipeline. In that form it latches the result one clock after the operands are presented with `in_valid`. A typical use is the swap decision of a sort loop on reduced-precision keys.

Top module: `bf16_gt_cmp`

## Requirements
- R1: When the sign bits (bit 31) differ, `gt_now` is 1 if A is the positive one and 0 if A is the negative one. This holds for zeros too, so +0 against -0 gives 1.
- R2: With both operands positive, a larger exponent field (bits 30:23, unsigned) in A gives 1, and a smaller one gives 0.
- R3: With both operands positive and equal exponents, a larger kept fraction (bits 22:16, unsigned) in A gives 1, and a smaller one gives 0.
- R4: With both operands negative, a smaller exponent in A gives 1. With equal exponents, a smaller kept fraction in A gives 1. The opposite orderings give 0.
- R5: When sign, exponent and kept fraction are all equal, the flag is 1 for two positive operands and 0 for two negative ones.
- R6: Bits 15:0 of either operand never change the flag.
- R7: `gt_now` depends only on the present operands, with no clock delay.
- R8: On the clock edge where `in_valid` is 1, `gt_q` takes that cycle's flag and `out_valid` becomes 1. `out_valid` is 1 after an edge exactly when `in_valid` was 1 at that edge.
- R9: `gt_q` keeps its value across edges where `in_valid` is 0.
- R10: Synchronous active-high `rst` clears both `out_valid` and `gt_q` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| a_word | input | 32 | Operand A, single-precision bit pattern |
| b_word | input | 32 | Operand B, single-precision bit pattern |
| gt_now | output | 1 | Combinational flag: A greater than B |
| out_valid | output | 1 | Registered result is fresh |
| gt_q | output | 1 | Registered flag |

## Verification
`gt_now` must be correct in the same cycle the operands settle. The bench drives operands just after a falling edge and samples the flag one time unit later, before any rising edge. The registered pair is due one rising edge after the operands with `in_valid`. A behavioural model in the bench updates on that same edge and is compared with `out_valid` and `gt_q` at every falling edge. As a result, a result that comes a cycle early or late, or a flag that is not held, shows up as a mismatch.

// File: rtl/bf16_cmp_pkg.sv
package bf16_cmp_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int KEEP_W = 7;
    localparam int KEY_W  = EXP_W + KEEP_W;

    typedef struct packed {
        logic              neg;
        logic [EXP_W-1:0]  expo;
        logic [KEEP_W-1:0] frac;
    } bf16_fields_t;

    typedef struct packed {
        logic valid;
        logic gt;
    } cmp_reg_t;
endpackage

// File: rtl/bf16_field_split.sv
module bf16_field_split
    import bf16_cmp_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_EXP  = EXP_W,
    parameter int W_FRAC = FRAC_W,
    parameter int W_KEEP = KEEP_W
) (
    input  logic [W_WORD-1:0] word,
    output bf16_fields_t      fields
);
    localparam int SIGN_POS = W_WORD - 1;
    localparam int EXP_TOP  = W_WORD - 2;
    localparam int FRAC_TOP = W_FRAC - 1;

    always_comb begin
        fields.neg  = word[SIGN_POS];
        fields.expo = word[EXP_TOP -: W_EXP];
        fields.frac = word[FRAC_TOP -: W_KEEP];
    end
endmodule

// File: rtl/bf16_key_cmp.sv
module bf16_key_cmp #(
    parameter int W = 15
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         lhs_gt,
    output logic         lhs_eq
);
    always_comb begin
        lhs_gt = (lhs > rhs);
        lhs_eq = (lhs == rhs);
    end
endmodule

// File: rtl/bf16_order_decide.sv
module bf16_order_decide
    import bf16_cmp_pkg::*;
(
    input  logic neg_a,
    input  logic neg_b,
    input  logic mag_gt,
    input  logic mag_eq,
    output logic a_greater
);
    always_comb begin
        if (neg_a != neg_b) begin
            a_greater = neg_b;
        end else if (!neg_a) begin
            a_greater = mag_gt | mag_eq;
        end else begin
            a_greater = !(mag_gt | mag_eq);
        end
    end
endmodule

// File: rtl/bf16_gt_cmp.sv
module bf16_gt_cmp
    import bf16_cmp_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int N_OPS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W_WORD-1:0] a_word,
    input  logic [W_WORD-1:0] b_word,
    output logic              gt_now,
    output logic              out_valid,
    output logic              gt_q
);
    localparam int KW = KEY_W;

    logic [W_WORD-1:0] op_words [N_OPS];
    bf16_fields_t      op_flds  [N_OPS];
    logic [KW-1:0]     op_keys  [N_OPS];

    assign op_words[0] = a_word;
    assign op_words[1] = b_word;

    for (genvar i = 0; i < N_OPS; i++) begin : g_split
        bf16_field_split #(.W_WORD(W_WORD)) u_split (
            .word   (op_words[i]),
            .fields (op_flds[i])
        );
        assign op_keys[i] = {op_flds[i].expo, op_flds[i].frac};
    end

    logic mag_gt, mag_eq, flag;

    bf16_key_cmp #(.W(KW)) u_key (
        .lhs    (op_keys[0]),
        .rhs    (op_keys[1]),
        .lhs_gt (mag_gt),
        .lhs_eq (mag_eq)
    );

    bf16_order_decide u_decide (
        .neg_a     (op_flds[0].neg),
        .neg_b     (op_flds[1].neg),
        .mag_gt    (mag_gt),
        .mag_eq    (mag_eq),
        .a_greater (flag)
    );

    cmp_reg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.gt = flag;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gt_now    = flag;
    assign out_valid = st_q.valid;
    assign gt_q      = st_q.gt;
endmodule

// File: rtl/bf16_gt_chk.sv
module bf16_gt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] a_word,
    input logic [31:0] b_word,
    input logic        gt_now,
    input logic        out_valid,
    input logic        gt_q
);
    p_pos_over_neg_r1: assert property (@(posedge clk) disable iff (rst)
        (!a_word[31] && b_word[31]) |-> gt_now);

    p_neg_under_pos_r1: assert property (@(posedge clk) disable iff (rst)
        (a_word[31] && !b_word[31]) |-> !gt_now);

    // R5: equal truncated patterns resolve by sign
    p_tie_by_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (a_word[31:16] == b_word[31:16]) |-> (gt_now == !a_word[31]));

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_flag_latch_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (gt_q == $past(gt_now)));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(gt_q));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !gt_q));
endmodule

bind bf16_gt_cmp bf16_gt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_word    (a_word),
    .b_word    (b_word),
    .gt_now    (gt_now),
    .out_valid (out_valid),
    .gt_q      (gt_q)
);

// File: tb/tb_bf16_gt_cmp.sv
`timescale 1ns/1ps
module tb_bf16_gt_cmp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] a_word = '0;
    logic [31:0] b_word = '0;
    logic        gt_now, out_valid, gt_q;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit m_valid = 1'b0;
    bit m_gt = 1'b0;

    always #2.5 clk = ~clk;

    bf16_gt_cmp dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_word(a_word), .b_word(b_word),
        .gt_now(gt_now), .out_valid(out_valid), .gt_q(gt_q)
    );

    // Behavioural reference: order of truncated values
    function automatic bit ref_gt(input logic [31:0] a, input logic [31:0] b);
        int ka, kb;
        ka = int'(a[30:16]);
        kb = int'(b[30:16]);
        if (a[31] != b[31]) return !a[31];
        if (!a[31]) return (ka >= kb);
        return (ka < kb);
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_valid <= 1'b0;
            m_gt    <= 1'b0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) m_gt <= ref_gt(a_word, b_word);
        end
    end

    // Registered outputs compared on every cycle (R8, R9, R10)
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (out_valid !== m_valid) begin
                errors++;
                $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, m_valid);
            end
            checks++;
            if (gt_q !== m_gt) begin
                errors++;
                $display("FAIL R9/R10 gt_q actual %0b expected %0b", gt_q, m_gt);
            end
        end
    end

    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input bit v, input bit exp, input string tag);
        @(negedge clk);
        a_word   = a;
        b_word   = b;
        in_valid = v;
        #1;
        checks++;
        if (gt_now !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual %0b expected %0b", tag, a, b, gt_now, exp);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 sign decides
        step(32'h0000_0000, 32'h8000_0000, 1, 1, "R1");
        step(32'h8000_0000, 32'h0000_0000, 1, 0, "R1");
        step(32'h3fcc_cccd, 32'hbfc0_0000, 0, 1, "R1");
        step(32'hbf80_0000, 32'h0000_0001, 1, 0, "R1");
        // R2 positive exponent
        step(32'h4000_0000, 32'h3f80_0000, 1, 1, "R2");
        step(32'h3f80_0000, 32'h4000_0000, 1, 0, "R2");
        // R3 positive kept fraction
        step(32'h3fcc_0000, 32'h3fb3_0000, 1, 1, "R3");
        step(32'h3fb3_0000, 32'h3fcc_0000, 0, 0, "R3");
        // R4 negative ordering
        step(32'hbf80_0000, 32'hc000_0000, 1, 1, "R4");
        step(32'hc000_0000, 32'hbf80_0000, 1, 0, "R4");
        step(32'hbfa6_0000, 32'hbfcc_0000, 0, 1, "R4");
        step(32'hbfcc_0000, 32'hbfa6_0000, 1, 0, "R4");
        // R5 ties
        step(32'h3f99_0000, 32'h3f99_0000, 1, 1, "R5");
        step(32'hbf99_0000, 32'hbf99_0000, 1, 0, "R5");
        // R6 low bits ignored
        step(32'h3f99_ffff, 32'h3f9a_0000, 1, 0, "R6");
        step(32'h3f99_0001, 32'h3f99_fffe, 1, 1, "R6");
        step(32'hbf99_abcd, 32'hbf99_1234, 1, 0, "R6");
        // R9 hold across idle cycles with changing operands
        step(32'h4000_0000, 32'h3f80_0000, 1, 1, "R9");
        step(32'h3f80_0000, 32'h4000_0000, 0, 0, "R9");
        step(32'h8000_0000, 32'h0000_0000, 0, 0, "R9");
        // R7 mixed patterns against the model
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = (i % 4 == 0) ? {ra[31:16], lfsr[15:0]} :
                 (i % 4 == 1) ? {ra[31:23], lfsr[22:0]} : lfsr;
            step(ra, rb, lfsr[3], ref_gt(ra, rb), "R7");
        end
        // R10 reset clears registered outputs
        step(32'h4000_0000, 32'h3f80_0000, 1, 1, "R10");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule